// File: doc/BRIEF.md
# Page-Program Write Buffer

This block gathers one full flash page of write data from software and sends it to a serial NOR flash as a single page-program frame. Software first switches the shared page storage from read-prefetch use to page-program use through a mode bit. It waits until the new mode can be read back, then pushes 32 little-endian 32-bit words into a data port. It then loads a 24-bit start address and writes the program command code. The block sends the opcode, the address and all 128 bytes as one uninterrupted serial frame, one bit per clock. The command-busy readback clears when the frame ends.

The storage is shared with a read-prefetch path that lives elsewhere. For that reason a mode change takes a settling delay before it becomes visible, and it is never applied while a frame is in flight. Pages that are only partly filled are not handled here. Software writes those tails byte by byte after switching back to read mode.

Top module: `ppb_page_writer`

## Requirements
- R1: After reset the mode readback is 0, the busy readback is 0, the chip select `fl_cs_n` is high, and every byte of the page storage holds 0x00.
- R2: A register write to offset 0x64 that is accepted takes bit 0 as the requested mode (0 = read prefetch, 1 = page program). The readback `cfg_mode_o` takes the new value exactly MODE_SETTLE clock edges after the edge that sampled the write. Writes to offset 0x64 while busy is high are ignored.
- R3: A write to the data port at offset 0x98 is stored only while the mode readback is 1 and busy is 0. Otherwise it leaves the storage unchanged.
- R4: Data word number i carries page bytes 4i to 4i+3. Byte 4i sits in bits 7:0, byte 4i+1 in bits 15:8, byte 4i+2 in bits 23:16 and byte 4i+3 in bits 31:24.
- R5: A fill pointer places accepted words at word 0, 1, 2 and onward. Once 32 words have been taken, further data writes are ignored until the pointer is reset. Words that are not rewritten keep their earlier contents.
- R6: The fill pointer returns to word 0 when a program command is accepted and each time the mode readback changes.
- R7: Writing code 0x10 in bits 7:0 at offset 0x00 starts a frame only when the mode readback is 1, no mode change is pending and busy is 0. Any other code, and any command issued in read-prefetch mode or while busy, is ignored.
- R8: A frame holds `fl_cs_n` low for exactly 8 + 24 + 1024 consecutive cycles and shows one bit on `fl_mosi` per cycle. It sends opcode 0x02 first, then the 24-bit address last written to offset 0x10 (bits 23:0), then the 128 page bytes in ascending address order. Every field is sent most significant bit first.
- R9: `cmd_busy_o` is 1 from the edge that accepts the command until the edge after the last bit. It falls in the same cycle that `fl_cs_n` rises.
- R10: The mode readback never changes while a frame is in flight. A mode change that is pending waits until the frame is over.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| cfg_mode_o | output | 1 | Mode readback (1 = page-program use) |
| cmd_busy_o | output | 1 | Command bit readback, high while the frame runs |
| fl_cs_n | output | 1 | Flash chip select, active low |
| fl_mosi | output | 1 | Serial data to flash, one bit per clock while selected |

## Verification
The bench builds the block with a 128-byte page and a 24-bit address, as in the defaults. It raises MODE_SETTLE to 3, so the readback latency is measured over several cycles rather than a single one. With this page size the stimulus can reach the 32-word fill limit, overflow writes, partial refills that leave stale words, and the full 1056-bit frame. The bench also issues data, mode and command writes while a frame is in flight, so the rules that freeze the block while busy are exercised.

// File: rtl/ppb_pkg.sv
// ppb_pkg: register offsets and command codes shared by the page-program
// write buffer and its checker. Assumes an 8-bit byte-offset register space.
package ppb_pkg;
    localparam logic [7:0] OFS_CMD  = 8'h00;  // command register
    localparam logic [7:0] OFS_ADDR = 8'h10;  // page start address
    localparam logic [7:0] OFS_CFG  = 8'h64;  // storage use select, bit 0
    localparam logic [7:0] OFS_DATA = 8'h98;  // 32-bit data push port

    localparam logic [7:0] CMD_PROGRAM = 8'h10;  // start page program
endpackage

// File: rtl/ppb_ctrl_regs.sv
// ppb_ctrl_regs: decodes register writes, holds the page address and the
// storage-use mode. A mode request settles over MODE_SETTLE edges before it
// becomes the active (readable) mode; settling is frozen while busy.
// Assumes MODE_SETTLE >= 1.
module ppb_ctrl_regs
    import ppb_pkg::*;
#(
    parameter int ADDR_W      = 24,
    parameter int DATA_W      = 32,
    parameter int MODE_SETTLE = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [7:0]        reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    input  logic              busy_i,
    output logic              mode_o,
    output logic              mode_flip_o,
    output logic [ADDR_W-1:0] page_addr_o,
    output logic              go_o,
    output logic              data_we_o
);
    localparam int SW = $clog2(MODE_SETTLE + 1);

    logic          mode_req_q;
    logic          mode_act_q;
    logic [SW-1:0] settle_q;
    logic          hit_cfg, hit_cmd, hit_data, hit_addr;
    logic          pending, settle_done;
    logic          unused_wd;

    // Address decode of the incoming write
    always_comb begin
        hit_cfg  = reg_wr && (reg_addr == OFS_CFG);
        hit_cmd  = reg_wr && (reg_addr == OFS_CMD);
        hit_data = reg_wr && (reg_addr == OFS_DATA);
        hit_addr = reg_wr && (reg_addr == OFS_ADDR);
    end

    assign unused_wd   = ^reg_wdata;
    assign pending     = (mode_req_q != mode_act_q);
    assign settle_done = pending && !busy_i && (settle_q == SW'(MODE_SETTLE - 1));

    // Capture the requested mode; ignored while a frame runs
    always_ff @(posedge clk) begin
        if (!rst_n)
            mode_req_q <= 1'b0;
        else if (hit_cfg && !busy_i)
            mode_req_q <= reg_wdata[0];
    end

    // Count the settling delay and apply the request when it expires
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_act_q <= 1'b0;
            settle_q   <= '0;
        end else if (settle_done) begin
            mode_act_q <= mode_req_q;
            settle_q   <= '0;
        end else if (pending && !busy_i) begin
            settle_q   <= settle_q + 1'b1;
        end else if (!pending) begin
            settle_q   <= '0;
        end
    end

    // Hold the page start address for the next frame
    always_ff @(posedge clk) begin
        if (!rst_n)
            page_addr_o <= '0;
        else if (hit_addr)
            page_addr_o <= reg_wdata[ADDR_W-1:0];
    end

    assign mode_o      = mode_act_q;
    assign mode_flip_o = settle_done;
    assign go_o        = hit_cmd && (reg_wdata[7:0] == CMD_PROGRAM) &&
                         mode_act_q && !pending && !busy_i;
    assign data_we_o   = hit_data && mode_act_q && !busy_i;
endmodule

// File: rtl/ppb_page_store.sv
// ppb_page_store: page storage filled word by word through a fill pointer,
// read back one byte at a time by byte index. Word i holds bytes
// WORD_BYTES*i upward, lowest byte in the least significant lane.
// Assumes PAGE_BYTES is a power-of-two multiple of WORD_BYTES.
module ppb_page_store #(
    parameter int PAGE_BYTES = 128,
    parameter int DATA_W     = 32
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          we_i,
    input  logic [DATA_W-1:0]             wdata_i,
    input  logic                          ptr_clr_i,
    input  logic [$clog2(PAGE_BYTES)-1:0] rd_idx_i,
    output logic [7:0]                    rd_byte_o
);
    localparam int WORD_BYTES = DATA_W / 8;
    localparam int WORDS      = PAGE_BYTES / WORD_BYTES;
    localparam int PW         = $clog2(WORDS + 1);
    localparam int BW         = $clog2(PAGE_BYTES);
    localparam int LW         = $clog2(WORD_BYTES);

    logic [DATA_W-1:0] mem_q [WORDS];
    logic [PW-1:0]     wptr_q;
    logic [WORDS-1:0]  wsel;
    logic              room;
    logic [DATA_W-1:0] rd_word;

    assign room = (wptr_q != PW'(WORDS));

    // One write-select line per storage word
    for (genvar g = 0; g < WORDS; g++) begin : g_sel
        assign wsel[g] = we_i && !ptr_clr_i && room && (wptr_q == PW'(g));
    end

    // Advance or clear the fill pointer
    always_ff @(posedge clk) begin
        if (!rst_n)
            wptr_q <= '0;
        else if (ptr_clr_i)
            wptr_q <= '0;
        else if (we_i && room)
            wptr_q <= wptr_q + 1'b1;
    end

    // Store the selected word; storage cleared on reset
    always_ff @(posedge clk) begin
        for (int w = 0; w < WORDS; w++) begin
            if (!rst_n)
                mem_q[w] <= '0;
            else if (wsel[w])
                mem_q[w] <= wdata_i;
        end
    end

    // Byte read mux: word by upper index bits, lane by lower bits
    always_comb begin
        rd_word   = mem_q[rd_idx_i[BW-1:LW]];
        rd_byte_o = rd_word[rd_idx_i[LW-1:0]*8 +: 8];
    end
endmodule

// File: rtl/ppb_burst_seq.sv
// ppb_burst_seq: runs one page-program frame. A single bit counter walks
// the header (opcode then address) and the page bytes, picking one bit per
// cycle, most significant bit first. Assumes PAGE_BYTES is a power of two.
module ppb_burst_seq #(
    parameter int         ADDR_W     = 24,
    parameter int         PAGE_BYTES = 128,
    parameter logic [7:0] OPCODE     = 8'h02
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          go_i,
    input  logic [ADDR_W-1:0]             addr_i,
    input  logic [7:0]                    rd_byte_i,
    output logic [$clog2(PAGE_BYTES)-1:0] rd_idx_o,
    output logic                          busy_o,
    output logic                          mosi_o
);
    localparam int HDR_BITS   = 8 + ADDR_W;
    localparam int FRAME_BITS = HDR_BITS + PAGE_BYTES * 8;
    localparam int KW         = $clog2(FRAME_BITS);
    localparam int HW         = $clog2(HDR_BITS);
    localparam int BW         = $clog2(PAGE_BYTES);

    logic                active_q;
    logic [KW-1:0]       k_q;
    logic [HDR_BITS-1:0] hdr_q;
    logic [KW-1:0]       doff;
    logic [HW-1:0]       hidx;
    logic                in_hdr;

    // Frame state: start on go, step one bit per cycle, stop after last
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active_q <= 1'b0;
            k_q      <= '0;
            hdr_q    <= '0;
        end else if (!active_q) begin
            if (go_i) begin
                active_q <= 1'b1;
                k_q      <= '0;
                hdr_q    <= {OPCODE, addr_i};
            end
        end else if (k_q == KW'(FRAME_BITS - 1)) begin
            active_q <= 1'b0;
            k_q      <= '0;
        end else begin
            k_q <= k_q + 1'b1;
        end
    end

    // Bit selection for the current frame position
    always_comb begin
        in_hdr   = (k_q < KW'(HDR_BITS));
        doff     = k_q - KW'(HDR_BITS);
        hidx     = HW'(HDR_BITS - 1) - k_q[HW-1:0];
        rd_idx_o = doff[BW+2:3];
        if (!active_q)
            mosi_o = 1'b0;
        else if (in_hdr)
            mosi_o = hdr_q[hidx];
        else
            mosi_o = rd_byte_i[~doff[2:0]];
    end

    assign busy_o = active_q;
endmodule

// File: rtl/ppb_page_writer.sv
// ppb_page_writer: top of the page-program write buffer. Register writes
// select the storage use, fill a page, load an address and start a frame;
// the frame is shifted out one bit per clock while fl_cs_n is low.
// Assumes the flash samples fl_mosi once per clk while selected.
module ppb_page_writer #(
    parameter int         PAGE_BYTES  = 128,
    parameter int         ADDR_W      = 24,
    parameter int         MODE_SETTLE = 2,
    parameter logic [7:0] PP_OPCODE   = 8'h02
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        reg_wr,
    input  logic [7:0]  reg_addr,
    input  logic [31:0] reg_wdata,
    output logic        cfg_mode_o,
    output logic        cmd_busy_o,
    output logic        fl_cs_n,
    output logic        fl_mosi
);
    localparam int DATA_W = 32;
    localparam int BW     = $clog2(PAGE_BYTES);

    logic              busy, mode_flip, go, data_we;
    logic [ADDR_W-1:0] page_addr;
    logic [BW-1:0]     rd_idx;
    logic [7:0]        rd_byte;

    ppb_ctrl_regs #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .MODE_SETTLE(MODE_SETTLE)
    ) u_regs (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .busy_i(busy), .mode_o(cfg_mode_o),
        .mode_flip_o(mode_flip), .page_addr_o(page_addr), .go_o(go),
        .data_we_o(data_we)
    );

    ppb_page_store #(
        .PAGE_BYTES(PAGE_BYTES), .DATA_W(DATA_W)
    ) u_store (
        .clk(clk), .rst_n(rst_n), .we_i(data_we), .wdata_i(reg_wdata),
        .ptr_clr_i(go || mode_flip), .rd_idx_i(rd_idx), .rd_byte_o(rd_byte)
    );

    ppb_burst_seq #(
        .ADDR_W(ADDR_W), .PAGE_BYTES(PAGE_BYTES), .OPCODE(PP_OPCODE)
    ) u_seq (
        .clk(clk), .rst_n(rst_n), .go_i(go), .addr_i(page_addr),
        .rd_byte_i(rd_byte), .rd_idx_o(rd_idx), .busy_o(busy),
        .mosi_o(fl_mosi)
    );

    assign cmd_busy_o = busy;
    assign fl_cs_n    = !busy;
endmodule

// File: rtl/ppb_page_writer_chk.sv
// ppb_page_writer_chk: protocol checker bound to ppb_page_writer. Counts
// selected cycles per frame and relates readbacks to register writes.
module ppb_page_writer_chk #(
    parameter int FRAME_BITS = 1056
) (
    input logic       clk,
    input logic       rst_n,
    input logic       reg_wr,
    input logic [7:0] reg_addr,
    input logic [7:0] cmd_code,
    input logic       cfg_mode_o,
    input logic       cmd_busy_o,
    input logic       fl_cs_n
);
    import ppb_pkg::*;

    logic [31:0] low_cnt;

    // Count consecutive selected cycles of the current frame
    always_ff @(posedge clk) begin
        if (!rst_n)
            low_cnt <= '0;
        else if (!fl_cs_n)
            low_cnt <= low_cnt + 1;
        else
            low_cnt <= '0;
    end

    // R8
    frame_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(fl_cs_n) |-> (low_cnt == FRAME_BITS));

    // R7
    start_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cmd_busy_o) |-> $past(reg_wr && (reg_addr == OFS_CMD) &&
                                    (cmd_code == CMD_PROGRAM) && cfg_mode_o));

    // R10
    mode_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(cfg_mode_o) |-> !$past(cmd_busy_o));

    // R2
    mode_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(reg_wr && (reg_addr == OFS_CFG)) |-> $stable(cfg_mode_o));
endmodule

bind ppb_page_writer ppb_page_writer_chk #(
    .FRAME_BITS(8 + ADDR_W + PAGE_BYTES * 8)
) u_chk (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .cmd_code(reg_wdata[7:0]), .cfg_mode_o(cfg_mode_o),
    .cmd_busy_o(cmd_busy_o), .fl_cs_n(fl_cs_n)
);

// File: tb/ppb_page_writer_bench.sv
module ppb_page_writer_bench;
    localparam int PAGE_BYTES  = 128;
    localparam int ADDR_W      = 24;
    localparam int MODE_SETTLE = 3;
    localparam int WORDS       = PAGE_BYTES / 4;
    localparam int FRAME_BITS  = 8 + ADDR_W + PAGE_BYTES * 8;

    localparam logic [7:0] A_CMD = 8'h00, A_ADDR = 8'h10, A_CFG = 8'h64, A_DATA = 8'h98;

    // {address, seed, words to push}
    localparam logic [63:0] VEC [4] = '{
        {24'h000100, 32'h11223344, 8'd32},
        {24'hFFFF80, 32'hA5C30F96, 8'd32},
        {24'h123456, 32'h0BADF00D, 8'd40},
        {24'h7F0000, 32'hCAFEBABE, 8'd10}
    };

    logic        clk = 1'b0, rst_n = 1'b0, reg_wr = 1'b0;
    logic [7:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic        cfg_mode_o, cmd_busy_o, fl_cs_n, fl_mosi;

    always #10 clk = ~clk;

    ppb_page_writer #(
        .PAGE_BYTES(PAGE_BYTES), .ADDR_W(ADDR_W), .MODE_SETTLE(MODE_SETTLE)
    ) u_ppb_page_writer (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .cfg_mode_o(cfg_mode_o), .cmd_busy_o(cmd_busy_o),
        .fl_cs_n(fl_cs_n), .fl_mosi(fl_mosi)
    );

    int checks = 0, fails = 0;
    bit finished = 0;
    logic [7:0] model [PAGE_BYTES];
    int mptr = 0;
    bit mmode = 0;
    logic [ADDR_W-1:0] cur_addr = '0;
    logic frame [FRAME_BITS + 64];
    int flen = 0;

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic put_word(input logic [31:0] w, input bit accepted);
        wr(A_DATA, w);
        if (accepted && mptr < WORDS) begin
            for (int b = 0; b < 4; b++) model[4*mptr + b] = w[8*b +: 8];
            mptr++;
        end
    endtask

    task automatic set_mode(input bit v);
        int n = 0;
        wr(A_CFG, {31'd0, v});
        while (cfg_mode_o !== v && n < 50) begin
            @(negedge clk);
            n++;
        end
        if (v != mmode) begin
            check(n == MODE_SETTLE, "R2", "mode readback latency", n, MODE_SETTLE);
            mptr = 0;  // R6: pointer cleared by mode change
        end
        mmode = v;
    endtask

    task automatic capture();
        flen = 0;
        while (!fl_cs_n && flen < FRAME_BITS + 64) begin
            frame[flen] = fl_mosi;
            flen++;
            @(negedge clk);
        end
    endtask

    task automatic verify(input string tag);
        logic [31:0] hdr = '0;
        int bad = 0, first = -1;
        logic [7:0] gb, fgot = '0, fexp = '0;
        check(flen == FRAME_BITS, "R8", {tag, " frame length"}, flen, FRAME_BITS);
        for (int i = 0; i < 32; i++) hdr = {hdr[30:0], frame[i]};
        check(hdr == {8'h02, cur_addr}, "R8", {tag, " opcode+address"}, hdr, {8'h02, cur_addr});
        for (int j = 0; j < PAGE_BYTES; j++) begin
            gb = '0;
            for (int b = 0; b < 8; b++) gb = {gb[6:0], frame[32 + 8*j + b]};
            if (gb !== model[j]) begin
                bad++;
                if (first < 0) begin first = j; fgot = gb; fexp = model[j]; end
            end
        end
        check(bad == 0, "R4", {tag, " payload first bad byte value"}, fgot, fexp);
    endtask

    task automatic run_burst(input string tag);
        wr(A_CMD, 32'h10);
        check(cmd_busy_o == 1'b1 && fl_cs_n == 1'b0, "R9", {tag, " busy after command"},
              cmd_busy_o, 1);
        capture();
        check(cmd_busy_o == 1'b0, "R9", {tag, " busy cleared with cs"}, cmd_busy_o, 0);
        verify(tag);
        mptr = 0;  // R6: pointer cleared by command
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!finished) begin
            checks++; fails++;
            $display("FAIL R9 watchdog: actual running expected finished");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [23:0] va;
        logic [31:0] vs;
        logic [7:0]  vn;
        int hi;
        for (int j = 0; j < PAGE_BYTES; j++) model[j] = 8'h00;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        check(cfg_mode_o == 0, "R1", "mode after reset", cfg_mode_o, 0);
        check(cmd_busy_o == 0, "R1", "busy after reset", cmd_busy_o, 0);
        check(fl_cs_n == 1, "R1", "cs after reset", fl_cs_n, 1);

        set_mode(1'b1);
        run_burst("R1 cleared storage");

        // Vector table: fill, overflow, partial refill
        for (int e = 0; e < 4; e++) begin
            {va, vs, vn} = VEC[e];
            wr(A_ADDR, {8'd0, va});
            cur_addr = va;
            for (int i = 0; i < int'(vn); i++) put_word(vs + i * 32'h01030507, 1'b1);
            run_burst("R5 table");
        end

        // R6: mode change clears pointer
        for (int i = 0; i < 5; i++) put_word(32'h50000000 + i, 1'b1);
        set_mode(1'b0);
        set_mode(1'b1);
        put_word(32'h99887766, 1'b1);
        run_burst("R6 flip");

        // R3 and R7: data and command ignored in read-prefetch mode
        set_mode(1'b0);
        put_word(32'hFFFFFFFF, 1'b0);
        wr(A_CMD, 32'h10);
        repeat (3) @(negedge clk);
        check(fl_cs_n == 1 && cmd_busy_o == 0, "R7", "command in mode 0", fl_cs_n, 1);
        set_mode(1'b1);
        run_burst("R3 ignored data");

        // R7: wrong command code ignored
        wr(A_CMD, 32'h11);
        repeat (3) @(negedge clk);
        check(fl_cs_n == 1, "R7", "wrong code ignored", fl_cs_n, 1);

        // R10, R2, R3, R7: writes during a frame are ignored
        wr(A_CMD, 32'h10);
        fork
            capture();
            begin
                wr(A_DATA, 32'hDEADBEEF);
                wr(A_CFG, 32'h0);
                wr(A_CMD, 32'h10);
            end
        join
        verify("R10 busy frame");
        mptr = 0;
        hi = 0;
        for (int i = 0; i < MODE_SETTLE + 6; i++) begin
            if (fl_cs_n == 1) hi++;
            @(negedge clk);
        end
        check(hi == MODE_SETTLE + 6, "R7", "command while busy ignored", hi, MODE_SETTLE + 6);
        check(cfg_mode_o == 1, "R2", "cfg write while busy ignored", cfg_mode_o, 1);
        run_burst("R3 busy data ignored");

        finished = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end
endmodule